// File: doc/BRIEF.md
# Fair Priority Bus Arbiter

This block decides which of several bus masters may drive a shared bus. Each master has a request line, a grant line and a release line, all separate and all wired to this single central arbiter. A master drives the bus only while its grant bit is high. It pulses its release bit in its last cycle of use. The arbiter always keeps exactly one owner. While that owner works, the arbiter is already choosing the next owner from the other requesters. In the cycle after the owner releases, the grant moves to that choice, so no idle cycle falls between two owners.

Lower master indices have higher priority. On its own, fixed priority would let a busy high-priority master starve a low-priority one. To prevent this, each requester has an age count of the handovers it has lost while waiting. Once that count reaches `AGE_LIMIT`, the requester moves above every ordinary requester. If no other master is waiting when the owner releases, the grant stays parked on that owner, which can start a new transfer without arbitration.

Top module: `fair_bus_arbiter`

## Requirements
- R1: While reset is held, and after it with no activity, the grant is `gnt_o == 1` (bit 0 only, master 0 parked).
- R2: Exactly one bit of `gnt_o` is high in every cycle; bit i belongs to master i, for `req_i`, `rel_i` and `gnt_o` alike.
- R3: `gnt_o` changes only on the clock edge that follows a cycle in which the current owner's `rel_i` bit was high.
- R4: A `rel_i` bit from a master that does not hold the grant has no effect on the grant.
- R5: When the owner releases and at least one other master requests, the grant moves on the next edge to a master whose request was high in the release cycle, with no cycle lacking an owner.
- R6: When the owner releases and no other master requests, the grant stays on the owner; the owner's own request never counts as competition.
- R7: Among waiting masters with none promoted, the lowest index wins the handover.
- R8: At each handover, every requesting master other than the winner and the old owner adds one to its age (saturating at `AGE_LIMIT`); an age clears when the master wins, gives up the bus, or drops its request. Masters whose age has reached `AGE_LIMIT` beat all others, lowest index first.
- R9: With all masters requesting and the owner releasing every cycle, the lowest-priority master is granted within `N_MASTERS*(AGE_LIMIT+1)` handovers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASTERS | Request per master, bit i for master i |
| rel_i | input | N_MASTERS | Release per master, high in the owner's last bus cycle |
| gnt_o | output | N_MASTERS | One-hot grant, bit i for master i |

## Verification
A release by the owner and an age promotion can take effect in the same cycle. That handover must then weigh fixed priority against the promoted set, while it also updates every other requester's age. The bench provokes this clash with long bursts in which all masters request while the owner releases every cycle, and with random request patterns mixed with random foreign release bits. A cycle-level model in the bench computes the expected owner and ages, and each handover is judged by the rule that decided it: plain priority, promotion, or parking.

// File: rtl/fba_pkg.sv
package fba_pkg;

   // index width that never collapses to zero bits
   function automatic int unsigned fba_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // age counter width able to hold 0..limit
   function automatic int unsigned fba_age_w(input int unsigned limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/fba_prio_pick.sv
module fba_prio_pick #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] cand_i,
   output logic [WIDTH-1:0] pick_o,
   output logic             any_o
);
   logic [WIDTH:0] seen;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_chain
         assign pick_o[i]   = cand_i[i] & ~seen[i];
         assign seen[i + 1] = seen[i] | cand_i[i];
      end
   endgenerate

   assign any_o = seen[WIDTH];

   always_comb begin
      assert (!any_o || $onehot(pick_o)) else $error("AST_PICK_ONEHOT"); // R7
   end
endmodule

// File: rtl/fba_age_cell.sv
module fba_age_cell
   import fba_pkg::*;
#(
   parameter int unsigned AGE_LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic owner_i,
   input  logic winner_i,
   input  logic handover_i,
   output logic urgent_o
);
   localparam int unsigned AW = fba_age_w(AGE_LIMIT);
   localparam logic [AW-1:0] LIM = AW'(AGE_LIMIT);

   logic [AW-1:0] age_q;
   logic [AW-1:0] age_d;

   always_comb begin
      age_d = age_q;
      if (!req_i) begin
         age_d = '0;
      end else if (handover_i) begin
         if (winner_i || owner_i) age_d = '0;
         else if (age_q < LIM)    age_d = age_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) age_q <= '0;
      else        age_q <= age_d;
   end

   assign urgent_o = req_i && !owner_i && (age_q >= LIM);

   AST_AGE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= LIM) else $error("AST_AGE_SAT"); // R8
   AST_AGE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> (age_q == '0)) else $error("AST_AGE_DROP"); // R8
   AST_AGE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (handover_i && winner_i) |=> (age_q == '0)) else $error("AST_AGE_WIN"); // R8
endmodule

// File: rtl/fba_grant_reg.sv
module fba_grant_reg #(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             handover_i,
   input  logic [WIDTH-1:0] win_i,
   input  logic [WIDTH-1:0] rel_i,
   output logic [WIDTH-1:0] gnt_o
);
   localparam logic [WIDTH-1:0] PARK_RST = WIDTH'(1);

   logic owner_rel;
   assign owner_rel = |(rel_i & gnt_o);

   always_ff @(posedge clk) begin
      if (!rst_n)          gnt_o <= PARK_RST;
      else if (handover_i) gnt_o <= win_i;
   end

   AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(gnt_o) == 1) else $error("AST_GNT_ONEHOT"); // R2
   AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !owner_rel |=> $stable(gnt_o)) else $error("AST_GNT_HOLD"); // R3
endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter
   import fba_pkg::*;
#(
   parameter int unsigned N_MASTERS = 4,
   parameter int unsigned AGE_LIMIT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [N_MASTERS-1:0] rel_i,
   output logic [N_MASTERS-1:0] gnt_o
);
   generate
      if (N_MASTERS < 2) begin : g_bad_n
         $error("N_MASTERS must be at least 2");
      end
      if (AGE_LIMIT < 1) begin : g_bad_age
         $error("AGE_LIMIT must be at least 1");
      end
   endgenerate

   logic [N_MASTERS-1:0] cand;
   logic [N_MASTERS-1:0] urgent;
   logic [N_MASTERS-1:0] pick_norm;
   logic [N_MASTERS-1:0] pick_urg;
   logic [N_MASTERS-1:0] winner;
   logic                 any_norm;
   logic                 any_urg;
   logic                 owner_rel;
   logic                 handover;

   // competitors exclude the current owner
   assign cand      = req_i & ~gnt_o;
   assign owner_rel = |(rel_i & gnt_o);
   assign handover  = owner_rel & any_norm;
   assign winner    = any_urg ? pick_urg : pick_norm;

   fba_prio_pick #(.WIDTH(N_MASTERS)) u_pick_norm (
      .cand_i (cand),
      .pick_o (pick_norm),
      .any_o  (any_norm)
   );

   fba_prio_pick #(.WIDTH(N_MASTERS)) u_pick_urg (
      .cand_i (urgent),
      .pick_o (pick_urg),
      .any_o  (any_urg)
   );

   generate
      for (genvar i = 0; i < N_MASTERS; i++) begin : g_age
         fba_age_cell #(.AGE_LIMIT(AGE_LIMIT)) u_age (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (req_i[i]),
            .owner_i    (gnt_o[i]),
            .winner_i   (winner[i]),
            .handover_i (handover),
            .urgent_o   (urgent[i])
         );
      end
   endgenerate

   fba_grant_reg #(.WIDTH(N_MASTERS)) u_gnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .handover_i (handover),
      .win_i      (winner),
      .rel_i      (rel_i),
      .gnt_o      (gnt_o)
   );

   AST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
      handover |=> (|(gnt_o & $past(req_i)) && (gnt_o != $past(gnt_o))))
      else $error("AST_HANDOVER"); // R5
   AST_PARK: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_rel && (cand == '0)) |=> $stable(gnt_o)) else $error("AST_PARK"); // R6
   AST_URG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (handover && any_urg) |=> |(gnt_o & $past(urgent))) else $error("AST_URG_FIRST"); // R8
endmodule

// File: tb/tb_fair_bus_arbiter.sv
module tb_fair_bus_arbiter;
   localparam int N = 4;
   localparam int L = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] rel = '0;
   logic [N-1:0] gnt;

   int n_chk = 0;
   int n_fail = 0;

   // bench model
   int m_own;
   int m_age [N];
   string m_tag;

   always #5 clk = ~clk;

   fair_bus_arbiter #(.N_MASTERS(N), .AGE_LIMIT(L)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .rel_i(rel), .gnt_o(gnt)
   );

   task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: gnt actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_own = 0;
      for (int i = 0; i < N; i++) m_age[i] = 0;
      m_tag = "R1";
   endtask

   function automatic int lowest(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) if (v[i]) return i;
      return -1;
   endfunction

   // apply one clock of inputs to the model (R3..R8)
   task automatic model_step(input logic [N-1:0] rq, input logic [N-1:0] rl);
      logic [N-1:0] cnd;
      logic [N-1:0] urg;
      int w;
      cnd = rq;
      cnd[m_own] = 1'b0;
      urg = '0;
      for (int i = 0; i < N; i++) if (cnd[i] && m_age[i] >= L) urg[i] = 1'b1;
      if (rl[m_own] && cnd != '0) begin
         w = (urg != '0) ? lowest(urg) : lowest(cnd);
         m_tag = (urg != '0) ? "R8" : "R7";
         for (int i = 0; i < N; i++) begin
            if (i == w || i == m_own || !rq[i]) m_age[i] = 0;
            else if (m_age[i] < L) m_age[i]++;
         end
         m_own = w;
      end else begin
         if (rl[m_own]) m_tag = "R6";
         else if (rl != '0) m_tag = "R4";
         else m_tag = "R3";
         for (int i = 0; i < N; i++) if (!rq[i]) m_age[i] = 0;
      end
   endtask

   // one cycle: check at negedge, then drive and step the model
   task automatic cycle(input logic [N-1:0] rq, input logic [N-1:0] rl);
      logic [N-1:0] exp;
      @(negedge clk);
      exp = '0;
      exp[m_own] = 1'b1;
      check(m_tag, gnt, exp);
      if ($countones(gnt) != 1) check("R2", gnt, exp);
      req = rq;
      rel = rl;
      model_step(rq, rl);
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [N-1:0] own_v;
      int hand;
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(negedge clk);
      check("R1", gnt, 4'b0001);
      rst_n = 1'b1;
      cycle('0, '0);
      cycle('0, '0);                       // R1 still parked on 0
      // R4: foreign release from masters 1..3 while 0 owns
      cycle(4'b0110, 4'b1110);
      cycle(4'b0110, 4'b0000);
      // R6: owner-only request, owner releases -> stays
      cycle(4'b0001, 4'b0001);
      cycle(4'b0000, 4'b0001);
      cycle(4'b0000, '0);
      // R5/R7: owner releases, 2 and 3 waiting -> 2
      cycle(4'b1100, 4'b0001);
      cycle(4'b1100, '0);
      cycle('0, '0);
      // R9: everyone requests, owner releases every cycle
      hand = 0;
      own_v = gnt;
      while (!gnt[N-1] && hand < 40) begin
         cycle('1, gnt);
         if (gnt != own_v) hand++;
         own_v = gnt;
      end
      n_chk++;
      if (!gnt[N-1] || hand > N * (L + 1)) begin
         n_fail++;
         $display("FAIL R9: handovers actual %0d expected <= %0d", hand, N * (L + 1));
      end
      cycle('0, '0);
      // random mix
      for (int k = 0; k < 4000; k++) begin
         logic [N-1:0] rq;
         logic [N-1:0] rl;
         rq = N'($urandom);
         rl = N'($urandom) & N'($urandom);
         if (($urandom % 3) == 0) rl = rl | gnt;
         if (($urandom % 4) == 0) rq = '1;
         cycle(rq, rl);
      end
      cycle('0, '0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule